// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit processor. It keeps an accumulator and five condition flags. On each cycle where an operation is requested it combines the accumulator with a second byte, which comes from a register or an immediate field, and writes the result back into the accumulator. In the same edge it updates the flags that the operation defines. The operations cover add and subtract, with and without carry or borrow. They also cover AND, OR, XOR, complement, increment, decrement, four rotates, clear and a plain copy.

The accumulator and flags are always visible as one 16-bit status word. The word has the accumulator in the high byte and the flags in the low byte, and a stack push stores it unchanged. A pop presents a saved word on a restore input, and the block reloads both the accumulator and the flags from it in one cycle. Register-file addressing, memory access and instruction sequencing belong to the surrounding core.

Top module: `alu8_flags_unit`

## Requirements
- R1: A synchronous active-high reset clears the accumulator and all five flags. Reset takes priority over the restore input and over any operation.
- R2: Results are registered. An operation or restore sampled at a rising edge shows on the outputs directly after that edge. With neither `op_valid` nor `psw_load` high, the accumulator and flags hold their values.
- R3: Addition uses code 0x0 (ADD, acc+operand) and code 0x1 (ADC, acc+operand+carry). The result is the sum mod 256. Carry takes the carry out of bit 7 and auxiliary carry takes the carry out of bit 3.
- R4: Subtraction uses code 0x2 (SUB, acc-operand) and code 0x3 (SBB, acc-operand-carry). The result is the difference mod 256. Carry is set on a borrow out of bit 7 and auxiliary carry is set on a borrow into bit 4.
- R5: The logic operations are code 0x4 (AND), code 0x5 (OR), code 0x6 (XOR) and code 0xE (clear to zero). Each of them clears both carry and auxiliary carry.
- R6: The operations with codes 0x0-0x6, 0x8, 0x9 and 0xE set zero when the result is 0, copy result bit 7 into sign, and set parity when the result has an even number of one bits.
- R7: Code 0x8 increments the accumulator and code 0x9 decrements it. Auxiliary carry is the carry out of bit 3 on increment and the borrow into bit 4 on decrement. Carry keeps its previous value.
- R8: The rotates change only the carry flag. Code 0xA rotates left and bit 7 goes to both bit 0 and carry. Code 0xB rotates right and bit 0 goes to both bit 7 and carry. Code 0xC rotates left through carry. Code 0xD rotates right through carry.
- R9: Code 0x7 complements the accumulator and leaves every flag unchanged.
- R10: Code 0xF copies the operand into the accumulator and leaves every flag unchanged.
- R11: The status word `psw_out` is {accumulator, 3'b000, sign, zero, aux carry, parity, carry}, with carry at bit 0 and sign at bit 4.
- R12: `psw_load` reloads the accumulator from `psw_in[15:8]` and the flags from `psw_in[4:0]`, in the R11 layout. Bits 7:5 of `psw_in` are ignored. The reload takes priority over a concurrent operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Perform `op_code` at this edge |
| op_code | input | 4 | Operation select (see R3-R10) |
| operand | input | 8 | Second operand, from a register or an immediate byte |
| psw_load | input | 1 | Restore the accumulator and flags from `psw_in` |
| psw_in | input | 16 | Status word popped from the stack |
| acc_out | output | 8 | Accumulator |
| flags_out | output | 5 | {sign, zero, aux carry, parity, carry} |
| psw_out | output | 16 | Status word for a stack push |

## Verification
Every result, whether from an operation or a restore, is due exactly one rising edge after its inputs are presented. Nothing is produced combinationally. The bench drives its inputs on the falling edge and advances its reference model at the next rising edge. At the falling edge after that it compares the accumulator, flags and status word. This samples each result half a cycle after it is registered and before the next stimulus. Idle cycles are checked the same way, so a value that drifts or changes early is caught on the cycle it appears.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int unsigned FLAG_W = 5;

  typedef enum logic [3:0] {
    OP_ADD = 4'h0,
    OP_ADC = 4'h1,
    OP_SUB = 4'h2,
    OP_SBB = 4'h3,
    OP_AND = 4'h4,
    OP_OR  = 4'h5,
    OP_XOR = 4'h6,
    OP_NOT = 4'h7,
    OP_INC = 4'h8,
    OP_DEC = 4'h9,
    OP_RLC = 4'hA,
    OP_RRC = 4'hB,
    OP_RAL = 4'hC,
    OP_RAR = 4'hD,
    OP_CLR = 4'hE,
    OP_MOV = 4'hF
  } alu_op_e;

  // bit 4 .. bit 0
  typedef struct packed {
    logic sign;
    logic zero;
    logic aux;
    logic par;
    logic cy;
  } alu_flags_t;

endpackage

// File: rtl/alu8_arith.sv
// Adder/subtractor split at the nibble boundary so the half carry falls out.
module alu8_arith #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,   // carry in (add) or borrow in (subtract)
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          cout,  // carry out or borrow out of the top bit
  output logic          hcout  // carry out of / borrow into the middle bit
);
  localparam int unsigned HW = DW / 2;
  localparam int unsigned UW = DW - HW;

  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic [HW:0]   lo_sum;
  logic [UW:0]   hi_sum;

  assign b_eff = sub ? ~b : b;
  assign c_eff = sub ? ~cin : cin;

  assign lo_sum = {1'b0, a[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
  assign hi_sum = {1'b0, a[DW-1:HW]} + {1'b0, b_eff[DW-1:HW]} + {{UW{1'b0}}, lo_sum[HW]};

  assign res   = {hi_sum[UW-1:0], lo_sum[HW-1:0]};
  assign cout  = sub ? ~hi_sum[UW] : hi_sum[UW];
  assign hcout = sub ? ~lo_sum[HW] : lo_sum[HW];
endmodule

// File: rtl/alu8_flaggen.sv
// Zero, sign and even-parity detection for one result word.
module alu8_flaggen #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] res,
  output logic          zero,
  output logic          sign,
  output logic          par_even
);
  logic [DW:0] chain;

  assign chain[0] = 1'b0;
  for (genvar i = 0; i < DW; i++) begin : g_par
    assign chain[i+1] = chain[i] ^ res[i];
  end

  assign zero     = (res == '0);
  assign sign     = res[DW-1];
  assign par_even = ~chain[DW];
endmodule

// File: rtl/alu8_datapath.sv
// Operation decode, result select and next-flag computation.
module alu8_datapath
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] operand,
  input  alu_flags_t    flags_cur,
  output logic [DW-1:0] res,
  output alu_flags_t    flags_nxt
);
  logic          is_incdec;
  logic [DW-1:0] ar_b;
  logic          ar_cin;
  logic          ar_sub;
  logic [DW-1:0] ar_res;
  logic          ar_cout;
  logic          ar_hc;
  logic          fz, fs, fp;

  assign is_incdec = (op == OP_INC) || (op == OP_DEC);
  assign ar_b      = is_incdec ? '0 : operand;
  assign ar_sub    = (op == OP_SUB) || (op == OP_SBB) || (op == OP_DEC);
  assign ar_cin    = is_incdec ? 1'b1
                   : ((op == OP_ADC) || (op == OP_SBB)) ? flags_cur.cy : 1'b0;

  alu8_arith #(.DW(DW)) u_arith (
    .a    (acc),
    .b    (ar_b),
    .cin  (ar_cin),
    .sub  (ar_sub),
    .res  (ar_res),
    .cout (ar_cout),
    .hcout(ar_hc)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB,
      OP_INC, OP_DEC: res = ar_res;
      OP_AND:         res = acc & operand;
      OP_OR:          res = acc | operand;
      OP_XOR:         res = acc ^ operand;
      OP_NOT:         res = ~acc;
      OP_RLC:         res = {acc[DW-2:0], acc[DW-1]};
      OP_RRC:         res = {acc[0], acc[DW-1:1]};
      OP_RAL:         res = {acc[DW-2:0], flags_cur.cy};
      OP_RAR:         res = {flags_cur.cy, acc[DW-1:1]};
      OP_CLR:         res = '0;
      default:        res = operand;  // OP_MOV
    endcase
  end

  alu8_flaggen #(.DW(DW)) u_flaggen (
    .res     (res),
    .zero    (fz),
    .sign    (fs),
    .par_even(fp)
  );

  always_comb begin
    flags_nxt = flags_cur;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        flags_nxt = '{sign: fs, zero: fz, aux: ar_hc, par: fp, cy: ar_cout};
      end
      OP_AND, OP_OR, OP_XOR, OP_CLR: begin
        flags_nxt = '{sign: fs, zero: fz, aux: 1'b0, par: fp, cy: 1'b0};
      end
      OP_INC, OP_DEC: begin
        flags_nxt = '{sign: fs, zero: fz, aux: ar_hc, par: fp, cy: flags_cur.cy};
      end
      OP_RLC, OP_RAL: flags_nxt.cy = acc[DW-1];
      OP_RRC, OP_RAR: flags_nxt.cy = acc[0];
      default: flags_nxt = flags_cur;  // OP_NOT, OP_MOV
    endcase
  end
endmodule

// File: rtl/alu8_state.sv
// Accumulator and flag registers with status-word restore.
module alu8_state
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic          psw_load,
  input  logic [2*DW-1:0] psw_in,
  input  logic [DW-1:0] res,
  input  alu_flags_t    flags_nxt,
  output logic [DW-1:0] acc,
  output alu_flags_t    flags
);
  logic unused_psw_pad;
  assign unused_psw_pad = ^psw_in[DW-1:FLAG_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      flags <= '0;
    end else if (psw_load) begin
      acc   <= psw_in[2*DW-1:DW];
      flags <= alu_flags_t'(psw_in[FLAG_W-1:0]);
    end else if (op_valid) begin
      acc   <= res;
      flags <= flags_nxt;
    end
  end
endmodule

// File: rtl/alu8_flags_unit.sv
module alu8_flags_unit
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_valid,
  input  logic [3:0]          op_code,
  input  logic [DW-1:0]       operand,
  input  logic                psw_load,
  input  logic [2*DW-1:0]     psw_in,
  output logic [DW-1:0]       acc_out,
  output logic [FLAG_W-1:0]   flags_out,
  output logic [2*DW-1:0]     psw_out
);
  localparam int unsigned PAD_W = DW - FLAG_W;

  logic [DW-1:0] acc_q;
  alu_flags_t    flags_q;
  logic [DW-1:0] res;
  alu_flags_t    flags_nxt;

  alu8_datapath #(.DW(DW)) u_datapath (
    .op       (alu_op_e'(op_code)),
    .acc      (acc_q),
    .operand  (operand),
    .flags_cur(flags_q),
    .res      (res),
    .flags_nxt(flags_nxt)
  );

  alu8_state #(.DW(DW)) u_state (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .psw_load (psw_load),
    .psw_in   (psw_in),
    .res      (res),
    .flags_nxt(flags_nxt),
    .acc      (acc_q),
    .flags    (flags_q)
  );

  assign acc_out   = acc_q;
  assign flags_out = flags_q;
  assign psw_out   = {acc_q, {PAD_W{1'b0}}, flags_q};
endmodule

// File: rtl/alu8_flags_unit_chk.sv
module alu8_flags_unit_chk
  import alu8_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic [DW-1:0]     operand,
  input logic              psw_load,
  input logic [2*DW-1:0]   psw_in,
  input logic [DW-1:0]     acc_out,
  input logic [FLAG_W-1:0] flags_out,
  input logic [2*DW-1:0]   psw_out
);
  logic do_op;
  logic zsp_op;
  logic logic_op;
  assign do_op    = op_valid && !psw_load;
  assign zsp_op   = do_op && (op_code <= 4'h6 || op_code == 4'h8 ||
                              op_code == 4'h9 || op_code == 4'hE);
  assign logic_op = do_op && (op_code == 4'h4 || op_code == 4'h5 ||
                              op_code == 4'h6 || op_code == 4'hE);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && flags_out == '0)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !psw_load) |=> ($stable(acc_out) && $stable(flags_out))); // R2

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    zsp_op |=> (flags_out[3] == (acc_out == '0))); // R6

  AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
    zsp_op |=> (flags_out[4] == acc_out[DW-1])); // R6

  AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (rst)
    zsp_op |=> (flags_out[1] == ~(^acc_out))); // R6

  AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
    logic_op |=> (flags_out[0] == 1'b0 && flags_out[2] == 1'b0)); // R5

  AST_INCDEC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (do_op && (op_code == 4'h8 || op_code == 4'h9)) |=> $stable(flags_out[0])); // R7

  AST_ROTATE_ONLY_CARRY: assert property (@(posedge clk) disable iff (rst)
    (do_op && op_code >= 4'hA && op_code <= 4'hD) |=> $stable(flags_out[4:1])); // R8

  AST_NOT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (do_op && op_code == 4'h7) |=> ($stable(flags_out) && acc_out == ~$past(acc_out))); // R9

  AST_MOV_COPIES: assert property (@(posedge clk) disable iff (rst)
    (do_op && op_code == 4'hF) |=> ($stable(flags_out) && acc_out == $past(operand))); // R10

  AST_RESTORE_WORD: assert property (@(posedge clk) disable iff (rst)
    psw_load |=> (psw_out == {$past(psw_in[2*DW-1:DW]), {(DW-FLAG_W){1'b0}},
                              $past(psw_in[FLAG_W-1:0])})); // R12
endmodule

bind alu8_flags_unit alu8_flags_unit_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_code  (op_code),
  .operand  (operand),
  .psw_load (psw_load),
  .psw_in   (psw_in),
  .acc_out  (acc_out),
  .flags_out(flags_out),
  .psw_out  (psw_out)
);

// File: tb/test_alu8_flags_unit.sv
module test_alu8_flags_unit;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = 4'h0;
  logic [7:0]  operand = 8'h00;
  logic        psw_load = 1'b0;
  logic [15:0] psw_in = 16'h0000;
  logic [7:0]  acc_out;
  logic [4:0]  flags_out;
  logic [15:0] psw_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  int m_acc = 0;
  bit m_s, m_z, m_ac, m_p, m_cy;

  always #5 clk = ~clk;

  alu8_flags_unit i_alu8_flags_unit (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .psw_load(psw_load), .psw_in(psw_in),
    .acc_out(acc_out), .flags_out(flags_out), .psw_out(psw_out)
  );

  function automatic void set_zsp();
    int ones = 0;
    for (int i = 0; i < 8; i++) if ((m_acc >> i) & 1) ones++;
    m_z = (m_acc == 0);
    m_s = (m_acc >= 128);
    m_p = (ones % 2 == 0);
  endfunction

  function automatic void model(input bit v, input bit ld, input int op,
                                input int b, input int pw);
    int t, h, ci;
    if (ld) begin
      m_acc = (pw >> 8) & 255;
      m_cy = pw[0]; m_p = pw[1]; m_ac = pw[2]; m_z = pw[3]; m_s = pw[4];
    end else if (v) begin
      case (op)
        0, 1: begin
          ci = (op == 1) ? int'(m_cy) : 0;
          t = m_acc + b + ci; h = (m_acc % 16) + (b % 16) + ci;
          m_cy = (t > 255); m_ac = (h > 15); m_acc = t % 256; set_zsp();
        end
        2, 3: begin
          ci = (op == 3) ? int'(m_cy) : 0;
          t = m_acc - b - ci; h = (m_acc % 16) - (b % 16) - ci;
          m_cy = (t < 0); m_ac = (h < 0); m_acc = (t + 512) % 256; set_zsp();
        end
        4, 5, 6, 14: begin
          if (op == 4) m_acc = m_acc & b;
          else if (op == 5) m_acc = m_acc | b;
          else if (op == 6) m_acc = m_acc ^ b;
          else m_acc = 0;
          m_cy = 0; m_ac = 0; set_zsp();
        end
        7: m_acc = 255 - m_acc;
        8: begin m_ac = (m_acc % 16 == 15); m_acc = (m_acc + 1) % 256; set_zsp(); end
        9: begin m_ac = (m_acc % 16 == 0); m_acc = (m_acc + 255) % 256; set_zsp(); end
        10: begin m_cy = (m_acc >= 128); m_acc = (m_acc * 2) % 256 + int'(m_cy); end
        11: begin m_cy = m_acc % 2; m_acc = m_acc / 2 + (m_cy ? 128 : 0); end
        12: begin t = int'(m_cy); m_cy = (m_acc >= 128); m_acc = (m_acc * 2) % 256 + t; end
        13: begin t = int'(m_cy); m_cy = m_acc % 2; m_acc = m_acc / 2 + (t ? 128 : 0); end
        default: m_acc = b;
      endcase
    end
  endfunction

  task automatic compare(input string req);
    logic [15:0] exp_w;
    exp_w = {m_acc[7:0], 3'b000, m_s, m_z, m_ac, m_p, m_cy};
    checks++;
    if (psw_out !== exp_w) begin
      failures++;
      $display("FAIL %s psw_out actual=%h expected=%h", req, psw_out, exp_w);
    end
    checks++;
    if ({acc_out, 3'b000, flags_out} !== exp_w) begin
      failures++;
      $display("FAIL R11 acc/flags actual=%h/%h expected=%h", acc_out, flags_out, exp_w);
    end
  endtask

  // called just after a falling edge
  task automatic step(input bit v, input bit ld, input int op, input int b,
                      input int pw, input string req);
    op_valid = v; psw_load = ld; op_code = op[3:0]; operand = b[7:0]; psw_in = pw[15:0];
    @(posedge clk);
    model(v, ld, op, b, pw);
    @(negedge clk);
    op_valid = 1'b0; psw_load = 1'b0;
    compare(req);
  endtask

  initial begin
    #(10 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates a concurrent operation and restore
    @(negedge clk);
    op_valid = 1'b1; op_code = 4'hF; operand = 8'h5A; psw_load = 1'b1; psw_in = 16'hFF1F;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0; psw_load = 1'b0;
    m_acc = 0; {m_s, m_z, m_ac, m_p, m_cy} = 5'b0;
    compare("R1");
    rst = 1'b0;

    step(1, 0, 15, 8'h3A, 0, "R10");      // MOV
    step(0, 0, 0, 8'hFF, 0, "R2");        // idle hold
    step(1, 0, 0, 8'hC6, 0, "R3");        // 3A+C6 = 100: zero, carry, aux
    step(1, 0, 1, 8'h01, 0, "R3");        // ADC with carry in
    step(1, 0, 0, 8'h08, 0, "R3");        // 02+08 no aux
    step(1, 0, 0, 8'h76, 0, "R6");        // 0A+76 = 80: sign, aux
    step(1, 0, 2, 8'h81, 0, "R4");        // 80-81 borrow
    step(1, 0, 3, 8'h00, 0, "R4");        // SBB borrow in
    step(1, 0, 2, 8'h0F, 0, "R4");        // FE-0F half borrow
    step(1, 0, 4, 8'h0F, 0, "R5");        // AND
    step(1, 0, 5, 8'hF0, 0, "R5");        // OR
    step(1, 0, 6, 8'hFF, 0, "R5");        // XOR
    step(1, 0, 7, 8'h00, 0, "R9");        // NOT
    step(1, 0, 10, 8'h00, 0, "R8");       // RLC sets carry
    step(1, 0, 15, 8'hFF, 0, "R10");      // MOV keeps carry
    step(1, 0, 8, 8'h00, 0, "R7");        // INC FF->00, carry kept
    step(1, 0, 9, 8'h00, 0, "R7");        // DEC 00->FF half borrow
    step(1, 0, 9, 8'h00, 0, "R7");
    step(1, 0, 11, 8'h00, 0, "R8");       // RRC
    step(1, 0, 12, 8'h00, 0, "R8");       // RAL
    step(1, 0, 13, 8'h00, 0, "R8");       // RAR
    step(1, 0, 14, 8'h00, 0, "R5");       // CLR
    step(1, 1, 15, 8'h11, 16'hA5F5, "R12"); // restore wins, pad bits ignored
    step(0, 0, 0, 8'h00, 0, "R2");
    step(0, 1, 0, 8'h00, 16'h3C0A, "R12");

    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 15);
      step(r != 0, r == 1, $urandom_range(0, 15), $urandom_range(0, 255),
           $urandom_range(0, 65535), "R6");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule